// File: doc/BRIEF.md
# Address-Value Delta Load Value Predictor

This block predicts the value that a pointer-producing load will return, so that a core running ahead past a long cache miss can still compute the addresses of loads that depend on it. It learns, for each static load, the difference between the load's effective address and the data it returned. Many linked structures are allocated with a regular layout, so this difference often stays the same from one access to the next.

Training comes from address loads retiring in normal mode. The caller presents the PC, the effective address and the returned data. The difference is formed as address minus data. Differences whose magnitude reaches the `MAX_AVD` bound are taken to come from data loads, and they are dropped. A lookup is made when a load misses in the second-level cache during runahead. The caller presents the PC and the effective address. One cycle later the block returns a predicted flag and the predicted value, which is the address minus the stored difference.

The table holds 16 entries, organised as 4 sets of 4 ways. The set is chosen by the low PC bits, and the rest of the PC forms the tag. Replacement is least recently trained. A wrong prediction needs no repair of the table.

Top module: `avd_pred`

## Requirements
- R1: After reset no entry is valid, `pred_valid_o` is 0, and every lookup returns no prediction until training has taken place.
- R2: The training difference is `train_addr_i - train_data_i`. A prediction returns `lookup_addr_i` minus the stored difference, sign-extended and modulo 2^ADDR_W. This holds for both positive and negative differences.
- R3: A training whose signed difference d does not satisfy -MAX_AVD < d < MAX_AVD leaves the table unchanged; MAX_AVD defaults to 64. A difference of ±(MAX_AVD-1) is accepted.
- R4: A newly written difference starts at confidence 0. Each training on a tag hit with an equal difference adds one, saturating at 3 with no wrap. A prediction needs confidence of at least 2, so the third equal training in a row enables it and later equal trainings keep it enabled.
- R5: A training on a tag hit with a different difference stores the new difference and sets the confidence back to 0.
- R6: A prediction needs a full tag match. The set is given by PC bits [1:0] and the tag by the remaining PC bits, so a PC in the same set with a different tag gets no prediction.
- R7: `pred_valid_o` is registered. It can be 1 only in the cycle after a cycle in which `lookup_valid_i` was 1.
- R8: `pred_value_o` is zero whenever `pred_valid_o` is 0.
- R9: A training in range that misses its set allocates the way that was trained least recently. Invalid ways are used up before any valid way is evicted.
- R10: Lookups change neither the table contents nor the recency order.
- R11: When a training and a lookup fall in the same cycle, the lookup sees the table as it stood before that training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_valid_i | input | 1 | An address load retires in normal mode |
| train_pc_i | input | PC_W | PC of the retiring load |
| train_addr_i | input | ADDR_W | Effective address of the retiring load |
| train_data_i | input | ADDR_W | Value returned by the retiring load |
| lookup_valid_i | input | 1 | A load misses in the second-level cache during runahead |
| lookup_pc_i | input | PC_W | PC of the missing load |
| lookup_addr_i | input | ADDR_W | Effective address of the missing load |
| pred_valid_o | output | 1 | A confident prediction is available |
| pred_value_o | output | ADDR_W | Predicted load value, zero when there is no prediction |

## Verification
The hardest case to reach is eviction of a confident entry. It needs all four ways of one set made confident, the recency order then changed by one more training, and the change shown to survive an intervening lookup. Only then does a fifth tag in that set reveal which way was replaced. The stimulus trains four PCs that share their low two bits three times each. It retrains the first of them, looks up the second, and then allocates a fifth tag. The second PC must lose its prediction while the other three keep theirs. The same-cycle case drives a training and a lookup on one clock edge, and the lookup must report the state from before the training.

// File: rtl/avd_pkg.sv
package avd_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_SAME  = 2'd1,
    UPD_NEW   = 2'd2,
    UPD_ALLOC = 2'd3
  } upd_e;
endpackage

// File: rtl/avd_delta_calc.sv
module avd_delta_calc #(
  parameter int ADDR_W  = 32,
  parameter int MAX_AVD = 64,
  parameter int DELTA_W = 7
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ADDR_W-1:0]  data_i,
  output logic [DELTA_W-1:0] delta_o,
  output logic               in_range_o
);
  localparam logic signed [ADDR_W-1:0] LIM = ADDR_W'(MAX_AVD);

  logic signed [ADDR_W-1:0] diff;

  assign diff       = $signed(addr_i - data_i);
  assign in_range_o = (diff > -LIM) && (diff < LIM);
  assign delta_o    = diff[DELTA_W-1:0];
endmodule

// File: rtl/avd_entry.sv
module avd_entry
  import avd_pkg::*;
#(
  parameter int TAG_W   = 30,
  parameter int DELTA_W = 7,
  parameter int CONF_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  upd_e               upd_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic               valid_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [DELTA_W-1:0] delta_o,
  output logic [CONF_W-1:0]  conf_o
);
  logic               valid_q;
  logic [TAG_W-1:0]   tag_q;
  logic [DELTA_W-1:0] delta_q;
  logic [CONF_W-1:0]  conf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      delta_q <= '0;
      conf_q  <= '0;
    end else begin
      case (upd_i)
        UPD_ALLOC: begin
          valid_q <= 1'b1;
          tag_q   <= tag_i;
          delta_q <= delta_i;
          conf_q  <= '0;
        end
        UPD_SAME: begin
          if (conf_q != '1) conf_q <= conf_q + 1'b1;
        end
        UPD_NEW: begin
          delta_q <= delta_i;
          conf_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign delta_o = delta_q;
  assign conf_o  = conf_q;
endmodule

// File: rtl/avd_lru.sv
module avd_lru #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  touch_i,
  input  logic [WAY_W-1:0]      touch_way_i,
  output logic [WAY_W-1:0]      victim_o,
  output logic [WAYS*WAY_W-1:0] age_o
);
  logic [WAY_W-1:0] age_q [WAYS];

  // age 0 = most recent; ages stay a permutation of 0..WAYS-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)              age_q[w] <= '0;
        else if (age_q[w] < age_q[touch_way_i])    age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign age_o[w*WAY_W +: WAY_W] = age_q[w];
  end
endmodule

// File: rtl/avd_pred.sv
module avd_pred
  import avd_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int MAX_AVD   = 64,
  parameter int CONF_W    = 2,
  parameter int PRED_CONF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              train_valid_i,
  input  logic [PC_W-1:0]   train_pc_i,
  input  logic [ADDR_W-1:0] train_addr_i,
  input  logic [ADDR_W-1:0] train_data_i,
  input  logic              lookup_valid_i,
  input  logic [PC_W-1:0]   lookup_pc_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_value_o
);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_W   = PC_W - IDX_W;
  localparam int DELTA_W = $clog2(MAX_AVD) + 1;
  localparam int ENT_W   = 1 + TAG_W + DELTA_W + CONF_W;
  localparam int ENT_ALL = SETS * WAYS * ENT_W;
  localparam int ST_W    = ENT_ALL + SETS * WAYS * WAY_W;

  logic               e_valid [SETS][WAYS];
  logic [TAG_W-1:0]   e_tag   [SETS][WAYS];
  logic [DELTA_W-1:0] e_delta [SETS][WAYS];
  logic [CONF_W-1:0]  e_conf  [SETS][WAYS];
  logic [WAY_W-1:0]   lru_victim [SETS];
  logic [WAYS*WAY_W-1:0] lru_age [SETS];
  logic [ST_W-1:0]    state_flat;

  // training path
  logic [DELTA_W-1:0] tr_delta;
  logic               tr_in_range;
  logic [IDX_W-1:0]   tr_idx;
  logic [TAG_W-1:0]   tr_tag;
  logic               tr_hit;
  logic [WAY_W-1:0]   tr_hit_way;
  logic               tr_same;
  logic               tr_acc;
  logic [WAY_W-1:0]   tr_way;

  avd_delta_calc #(
    .ADDR_W (ADDR_W),
    .MAX_AVD(MAX_AVD),
    .DELTA_W(DELTA_W)
  ) i_delta (
    .addr_i    (train_addr_i),
    .data_i    (train_data_i),
    .delta_o   (tr_delta),
    .in_range_o(tr_in_range)
  );

  assign tr_idx = train_pc_i[IDX_W-1:0];
  assign tr_tag = train_pc_i[PC_W-1:IDX_W];

  always_comb begin
    tr_hit     = 1'b0;
    tr_hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (e_valid[tr_idx][w] && e_tag[tr_idx][w] == tr_tag) begin
        tr_hit     = 1'b1;
        tr_hit_way = WAY_W'(w);
      end
    end
    tr_same = (e_delta[tr_idx][tr_hit_way] == tr_delta);
  end

  assign tr_acc = train_valid_i && tr_in_range;
  assign tr_way = tr_hit ? tr_hit_way : lru_victim[tr_idx];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_sel;
    assign set_sel = tr_acc && (tr_idx == IDX_W'(s));

    avd_lru #(
      .WAYS (WAYS),
      .WAY_W(WAY_W)
    ) i_lru (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .touch_i    (set_sel),
      .touch_way_i(tr_way),
      .victim_o   (lru_victim[s]),
      .age_o      (lru_age[s])
    );

    assign state_flat[ENT_ALL + s*WAYS*WAY_W +: WAYS*WAY_W] = lru_age[s];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      upd_e upd;

      always_comb begin
        upd = UPD_NONE;
        if (set_sel && tr_way == WAY_W'(w)) begin
          if (!tr_hit)      upd = UPD_ALLOC;
          else if (tr_same) upd = UPD_SAME;
          else              upd = UPD_NEW;
        end
      end

      avd_entry #(
        .TAG_W  (TAG_W),
        .DELTA_W(DELTA_W),
        .CONF_W (CONF_W)
      ) i_entry (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (upd),
        .tag_i  (tr_tag),
        .delta_i(tr_delta),
        .valid_o(e_valid[s][w]),
        .tag_o  (e_tag[s][w]),
        .delta_o(e_delta[s][w]),
        .conf_o (e_conf[s][w])
      );

      assign state_flat[(s*WAYS + w)*ENT_W +: ENT_W] =
        {e_valid[s][w], e_tag[s][w], e_delta[s][w], e_conf[s][w]};
    end
  end

  // lookup path, reads pre-update state
  logic [IDX_W-1:0]   lk_idx;
  logic [TAG_W-1:0]   lk_tag;
  logic               lk_hit;
  logic [DELTA_W-1:0] lk_delta;
  logic [CONF_W-1:0]  lk_conf;
  logic               pred_d;
  logic [ADDR_W-1:0]  value_d;
  logic               pred_q;
  logic [ADDR_W-1:0]  value_q;

  assign lk_idx = lookup_pc_i[IDX_W-1:0];
  assign lk_tag = lookup_pc_i[PC_W-1:IDX_W];

  always_comb begin
    lk_hit   = 1'b0;
    lk_delta = '0;
    lk_conf  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (e_valid[lk_idx][w] && e_tag[lk_idx][w] == lk_tag) begin
        lk_hit   = 1'b1;
        lk_delta = e_delta[lk_idx][w];
        lk_conf  = e_conf[lk_idx][w];
      end
    end
  end

  assign pred_d  = lookup_valid_i && lk_hit && (lk_conf >= CONF_W'(PRED_CONF));
  assign value_d = pred_d
    ? lookup_addr_i - {{(ADDR_W-DELTA_W){lk_delta[DELTA_W-1]}}, lk_delta}
    : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q  <= 1'b0;
      value_q <= '0;
    end else begin
      pred_q  <= pred_d;
      value_q <= value_d;
    end
  end

  assign pred_valid_o = pred_q;
  assign pred_value_o = value_q;
endmodule

// File: rtl/avd_pred_chk.sv
module avd_pred_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_AVD = 64,
  parameter int ST_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              train_valid_i,
  input logic [ADDR_W-1:0] train_addr_i,
  input logic [ADDR_W-1:0] train_data_i,
  input logic              lookup_valid_i,
  input logic              pred_valid_o,
  input logic [ADDR_W-1:0] pred_value_o,
  input logic [ST_W-1:0]   state_i
);
  localparam logic signed [ADDR_W-1:0] BOUND = ADDR_W'(MAX_AVD);

  logic signed [ADDR_W-1:0] chk_diff;
  logic                     wide;

  assign chk_diff = $signed(train_addr_i - train_data_i);
  assign wide     = (chk_diff >= BOUND) || (chk_diff <= -BOUND);

  a_r3_wide_delta_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(train_valid_i && wide) |-> $stable(state_i));

  a_r7_pred_follows_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> $past(lookup_valid_i));

  a_r8_idle_value_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> (pred_value_o == '0));

  a_r10_lookup_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(train_valid_i) |-> $stable(state_i));
endmodule

bind avd_pred avd_pred_chk #(
  .ADDR_W (ADDR_W),
  .MAX_AVD(MAX_AVD),
  .ST_W   (ST_W)
) i_avd_pred_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .train_valid_i (train_valid_i),
  .train_addr_i  (train_addr_i),
  .train_data_i  (train_data_i),
  .lookup_valid_i(lookup_valid_i),
  .pred_valid_o  (pred_valid_o),
  .pred_value_o  (pred_value_o),
  .state_i       (state_flat)
);

// File: tb/test_avd_pred.sv
`timescale 1ns/1ps
module test_avd_pred;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        train_valid_i = 1'b0;
  logic [31:0] train_pc_i = '0;
  logic [31:0] train_addr_i = '0;
  logic [31:0] train_data_i = '0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_pc_i = '0;
  logic [31:0] lookup_addr_i = '0;
  logic        pred_valid_o;
  logic [31:0] pred_value_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  avd_pred i_avd_pred (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .train_valid_i (train_valid_i),
    .train_pc_i    (train_pc_i),
    .train_addr_i  (train_addr_i),
    .train_data_i  (train_data_i),
    .lookup_valid_i(lookup_valid_i),
    .lookup_pc_i   (lookup_pc_i),
    .lookup_addr_i (lookup_addr_i),
    .pred_valid_o  (pred_valid_o),
    .pred_value_o  (pred_value_o)
  );

  task automatic check(input string req, input logic exp_v, input logic [31:0] exp_val);
    n_chk++;
    if (pred_valid_o !== exp_v || pred_value_o !== exp_val) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b value=%h, expected valid=%0b value=%h",
               req, pred_valid_o, pred_value_o, exp_v, exp_val);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    train_valid_i = 1'b0;
    lookup_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] addr, input int d);
    @(negedge clk_i);
    train_valid_i = 1'b1;
    train_pc_i    = pc;
    train_addr_i  = addr;
    train_data_i  = addr - 32'(d);
    @(negedge clk_i);
    train_valid_i = 1'b0;
  endtask

  task automatic train_n(input logic [31:0] pc, input logic [31:0] addr, input int d, input int n);
    for (int i = 0; i < n; i++) train(pc, addr, d);
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic [31:0] addr,
                      input logic exp_v, input logic [31:0] exp_val);
    @(negedge clk_i);
    lookup_valid_i = 1'b1;
    lookup_pc_i    = pc;
    lookup_addr_i  = addr;
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    check(req, exp_v, exp_val);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset outputs", 1'b0, 32'h0);
    look("R1 lookup on empty table", 32'h10, 32'h1000, 1'b0, 32'h0);
  endtask

  task automatic t_ramp();
    do_reset();
    train(32'h1001, 32'h8000, 16);
    look("R4 conf0 no prediction", 32'h1001, 32'h8000, 1'b0, 32'h0);
    train(32'h1001, 32'h8000, 16);
    look("R8 conf1 value zero", 32'h1001, 32'h8000, 1'b0, 32'h0);
    train(32'h1001, 32'h8000, 16);
    look("R4 third equal training predicts", 32'h1001, 32'h8000, 1'b1, 32'h8000 - 32'd16);
    train(32'h1001, 32'h8000, 16);
    look("R4 fourth training no wrap", 32'h1001, 32'h8000, 1'b1, 32'h7ff0);
    train_n(32'h1001, 32'h8000, 16, 2);
    look("R2 value from lookup address", 32'h1001, 32'h9000, 1'b1, 32'h8ff0);
  endtask

  task automatic t_change();
    do_reset();
    train_n(32'h2002, 32'hA000, 8, 3);
    look("R5 confident before change", 32'h2002, 32'hA000, 1'b1, 32'h9ff8);
    train(32'h2002, 32'hA000, 24);
    look("R5 changed delta resets conf", 32'h2002, 32'hA000, 1'b0, 32'h0);
    train(32'h2002, 32'hA000, 24);
    look("R5 one more still unconfident", 32'h2002, 32'hA000, 1'b0, 32'h0);
    train(32'h2002, 32'hA000, 24);
    look("R5 new delta predicted", 32'h2002, 32'hA000, 1'b1, 32'h9fe8);
  endtask

  task automatic t_negative();
    do_reset();
    train_n(32'h3003, 32'h4000, -40, 3);
    look("R2 negative delta", 32'h3003, 32'h5000, 1'b1, 32'h5028);
    train_n(32'h3007, 32'h0000_0010, 32, 3);
    look("R2 modulo wrap", 32'h3007, 32'h0000_0004, 1'b1, 32'hFFFF_FFE4);
  endtask

  task automatic t_range();
    do_reset();
    train_n(32'h4001, 32'h6000, 5, 3);
    train(32'h4001, 32'h6000, 64);
    look("R3 delta +64 ignored", 32'h4001, 32'h6000, 1'b1, 32'h5ffb);
    train(32'h4001, 32'h6000, -64);
    look("R3 delta -64 ignored", 32'h4001, 32'h6000, 1'b1, 32'h5ffb);
    train(32'h4001, 32'h6000, 32'h0010_0000);
    look("R3 huge delta ignored", 32'h4001, 32'h6000, 1'b1, 32'h5ffb);
    train(32'h4001, 32'h6000, 63);
    look("R3 delta 63 accepted", 32'h4001, 32'h6000, 1'b0, 32'h0);
    train_n(32'h4001, 32'h6000, 63, 2);
    look("R3 delta 63 predicted", 32'h4001, 32'h6000, 1'b1, 32'h5fc1);
    train_n(32'h4005, 32'h6000, -63, 3);
    look("R3 delta -63 predicted", 32'h4005, 32'h6000, 1'b1, 32'h603f);
    train_n(32'h4009, 32'h6000, 64, 3);
    look("R3 wide delta never allocates", 32'h4009, 32'h6000, 1'b0, 32'h0);
  endtask

  task automatic t_tag();
    do_reset();
    train_n(32'h201, 32'h1200, 12, 3);
    look("R6 other tag same set", 32'h301, 32'h1200, 1'b0, 32'h0);
    look("R6 other set", 32'h202, 32'h1200, 1'b0, 32'h0);
    look("R6 matching tag", 32'h201, 32'h1200, 1'b1, 32'h11f4);
  endtask

  task automatic t_latency();
    do_reset();
    train_n(32'h501, 32'h2000, 4, 3);
    look("R7 registered prediction", 32'h501, 32'h2000, 1'b1, 32'h1ffc);
    @(negedge clk_i);
    check("R7 no prediction without lookup", 1'b0, 32'h0);
  endtask

  task automatic t_lru();
    do_reset();
    train_n(32'h100, 32'h3000, 1, 3);
    train_n(32'h104, 32'h3000, 2, 3);
    train_n(32'h108, 32'h3000, 3, 3);
    train_n(32'h10C, 32'h3000, 4, 3);
    train(32'h100, 32'h3000, 1);
    look("R10 lookup of oldest way", 32'h104, 32'h3000, 1'b1, 32'h2ffe);
    train(32'h110, 32'h3000, 5);
    look("R9 LRU way evicted", 32'h104, 32'h3000, 1'b0, 32'h0);
    look("R9 retrained way kept", 32'h100, 32'h3000, 1'b1, 32'h2fff);
    look("R9 way 3 kept", 32'h108, 32'h3000, 1'b1, 32'h2ffd);
    look("R9 way 4 kept", 32'h10C, 32'h3000, 1'b1, 32'h2ffc);
  endtask

  task automatic t_same_cycle();
    do_reset();
    train_n(32'h601, 32'h7000, 9, 2);
    @(negedge clk_i);
    train_valid_i  = 1'b1;
    train_pc_i     = 32'h601;
    train_addr_i   = 32'h7000;
    train_data_i   = 32'h7000 - 32'd9;
    lookup_valid_i = 1'b1;
    lookup_pc_i    = 32'h601;
    lookup_addr_i  = 32'h7000;
    @(negedge clk_i);
    train_valid_i  = 1'b0;
    lookup_valid_i = 1'b0;
    check("R11 lookup sees pre-update state", 1'b0, 32'h0);
    look("R11 update visible next cycle", 32'h601, 32'h7000, 1'b1, 32'h6ff7);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_change();
    t_negative();
    t_range();
    t_tag();
    t_latency();
    t_lru();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule